// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block is one DMA channel with two buffer descriptors, A and B, that take turns. Each descriptor holds a start address and a transfer count. Software arms a descriptor by setting its start bit. The channel then moves the buffer one beat at a time, paced by a peripheral request line and a simple valid/ready beat handshake. When a buffer's count is used up, the channel marks that buffer done and hands over to the other descriptor. If the other descriptor is armed, transfers continue without a gap in software attention. If it is not armed, the channel goes idle.

Software reaches the block through a single register port with a 3-bit select. A device word describes the peripheral: its direction, byte order, burst size, beat width, a 4-bit select and a 24-bit peripheral address. The channel control word is never written directly. Software writes ones to a set alias or a clear alias and reads the result from a status alias. A descriptor whose start bit is set refuses address and count writes, so an armed buffer cannot be changed under the engine.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset every control bit is 0, the in-use flag selects A, the device word reads 0, `irq` is low and `xfer_valid` is low.
- R2: Select encodings are 0 device word, 1 set alias, 2 clear alias, 3 status alias, 4 address A, 5 count A, 6 address B, 7 count B. Reading selects 1, 2 or 3 returns the status word: bit0 run, bit1 interrupt enable, bit2 done A, bit3 start A, bit4 done B, bit5 start B, bit6 in-use (1 = B). Writing to the set alias sets each bit 0..5 written as 1, and writing to the clear alias clears each one. Bit 6 and writes to the status alias have no effect.
- R3: A write to a descriptor's address or count is ignored while that descriptor's start bit is set, or while it is the in-use descriptor with a beat outstanding.
- R4: While the device word is all zero, the channel issues no beat.
- R5: A beat is issued only while run is set, the in-use descriptor is started, its count is nonzero and `periph_req` is high. `xfer_valid` stays high with a stable `xfer_addr` until `xfer_ready`. The beat carries device bit 0 (1 = receive) on `xfer_rx`, bit 3 on `xfer_wide` and bits 7:4 on `xfer_dev`.
- R6: Each accepted beat advances the in-use address by the beat size, which is 2 bytes when device bit 3 is set and 1 byte otherwise. It lowers the count by the same amount, stopping at 0.
- R7: When the in-use count reaches 0, that descriptor's done bit is set, its start bit is cleared and the in-use flag flips. Transfers go on from the other descriptor only if its start bit is set. A descriptor started with a count of 0 completes this way without a beat.
- R8: Clearing run stops new beats. The status run bit stays 1 until an outstanding beat has been accepted. Setting run again resumes the transfer where it stopped.
- R9: `irq` equals interrupt enable AND (done A OR done B). A done bit falls only through a clear-alias write. A completion in the same cycle as such a clear leaves the done bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| periph_req | input | 1 | Peripheral asks for data movement |
| xfer_ready | input | 1 | Beat accepted this cycle |
| xfer_valid | output | 1 | Beat outstanding |
| xfer_addr | output | ADDR_W | Memory address of the beat |
| xfer_rx | output | 1 | Beat direction, 1 = receive |
| xfer_wide | output | 1 | Beat is 2 bytes |
| xfer_dev | output | 4 | Peripheral select of the beat |
| irq | output | 1 | Channel interrupt |

## Verification
The bench targets the handover between descriptors. A channel that failed to flip the in-use flag would refill the same buffer, and one that ignored the other start bit would run on into an unarmed descriptor. A 2-byte transfer with an odd count must stop at zero rather than wrap and run forever. A descriptor armed with a zero count must complete without driving a beat. The bench pauses the channel while a beat is held by a low `xfer_ready`. There the status run bit must stay high until acceptance, and a design that dropped the beat or let its address change would break the stream. The bench also confirms that writes to an armed descriptor and writes to a channel with a zero device word leave the channel's state untouched.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SEL_CFG    = 3'd0,
        SEL_SET    = 3'd1,
        SEL_CLR    = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_ADDR_A = 3'd4,
        SEL_CNT_A  = 3'd5,
        SEL_ADDR_B = 3'd6,
        SEL_CNT_B  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [23:0] dev_addr;
        logic [3:0]  dev_sel;
        logic        wide;
        logic        burst;
        logic        big_end;
        logic        rx;
    } dev_cfg_t;

    typedef struct packed {
        logic biu;
        logic start_b;
        logic done_b;
        logic start_a;
        logic done_a;
        logic ie;
        logic run;
    } chan_ctl_t;

    localparam int CTL_W = $bits(chan_ctl_t);
    localparam int SW_W  = CTL_W - 1;

    function automatic logic [1:0] beat_bytes(input logic wide);
        return wide ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/pp_dma_ctl.sv
module pp_dma_ctl
    import pp_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [SW_W-1:0] sw_bits,
    input  logic            complete,
    output chan_ctl_t       ctl,
    output logic            irq
);

    chan_ctl_t       ctl_nxt;
    logic [SW_W-1:0] low;

    always_comb begin
        low = ctl[SW_W-1:0];
        if (set_we) low = low | sw_bits;
        if (clr_we) low = low & ~sw_bits;
        ctl_nxt = chan_ctl_t'({ctl.biu, low});
        if (complete) begin
            if (ctl.biu) begin
                ctl_nxt.done_b  = 1'b1;
                ctl_nxt.start_b = 1'b0;
            end else begin
                ctl_nxt.done_a  = 1'b1;
                ctl_nxt.start_a = 1'b0;
            end
            ctl_nxt.biu = ~ctl.biu;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl <= '0;
        else     ctl <= ctl_nxt;
    end

    assign irq = ctl.ie & (ctl.done_a | ctl.done_b);

    assert_done_a_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.done_a && !(clr_we && sw_bits[2])) |=> ctl.done_a);

    assert_done_b_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.done_b && !(clr_we && sw_bits[4])) |=> ctl.done_b);

    assert_swap_on_complete_R7: assert property (@(posedge clk) disable iff (rst)
        complete |=> (ctl.biu != $past(ctl.biu)));

endmodule

// File: rtl/pp_dma_desc.sv
module pp_dma_desc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              lock,
    input  logic              adv,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt
);

    logic [CNT_W-1:0] step_c;
    assign step_c = CNT_W'(step);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
        end else if (adv) begin
            addr <= addr + ADDR_W'(step);
            cnt  <= (cnt <= step_c) ? '0 : cnt - step_c;
        end else if (!lock) begin
            if (wr_addr) addr <= wdata;
            if (wr_cnt)  cnt  <= wdata[CNT_W-1:0];
        end
    end

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (rst)
        (lock && !adv) |=> ($stable(addr) && $stable(cnt)));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        adv |=> (addr == $past(addr) + ADDR_W'($past(step))));

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import pp_dma_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_ctl_t        ctl,
    input  logic             alloc,
    input  logic [CNT_W-1:0] cnt_act,
    input  logic [1:0]       step,
    input  logic             periph_req,
    input  logic             xfer_ready,
    output logic             inflight,
    output logic             adv,
    output logic             complete
);

    logic start_act, may_go, empty, last, issue;

    assign start_act = ctl.biu ? ctl.start_b : ctl.start_a;
    assign may_go    = !inflight && ctl.run && alloc && start_act;
    assign empty     = (cnt_act == '0);
    assign last      = (cnt_act <= CNT_W'(step));
    assign adv       = inflight && xfer_ready;
    assign complete  = (adv && last) || (may_go && empty);
    assign issue     = may_go && !empty && periph_req;

    always_ff @(posedge clk) begin
        if (rst)        inflight <= 1'b0;
        else if (adv)   inflight <= 1'b0;
        else if (issue) inflight <= 1'b1;
    end

    assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (inflight && !xfer_ready) |=> inflight);

    assert_unalloc_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!alloc && !inflight) |=> !inflight);

    assert_paused_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !inflight) |=> !inflight);

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    input  logic              xfer_ready,
    output logic              xfer_valid,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_rx,
    output logic              xfer_wide,
    output logic [3:0]        xfer_dev,
    output logic              irq
);

    localparam int NBUF = 2;

    reg_sel_e  sel;
    dev_cfg_t  cfg;
    chan_ctl_t ctl;
    logic      inflight, adv, complete, alloc;
    logic [1:0] step;
    logic [NBUF-1:0] start_v;
    logic [ADDR_W-1:0] addr_q [NBUF];
    logic [CNT_W-1:0]  cnt_q  [NBUF];
    logic [REG_W-1:0]  stat_word;

    assign sel     = reg_sel_e'(reg_sel);
    assign alloc   = |cfg;
    assign step    = beat_bytes(cfg.wide);
    assign start_v = {ctl.start_b, ctl.start_a};

    always_ff @(posedge clk) begin
        if (rst)                           cfg <= '0;
        else if (reg_we && sel == SEL_CFG) cfg <= dev_cfg_t'(reg_wdata);
    end

    pp_dma_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .set_we   (reg_we && sel == SEL_SET),
        .clr_we   (reg_we && sel == SEL_CLR),
        .sw_bits  (reg_wdata[SW_W-1:0]),
        .complete (complete),
        .ctl      (ctl),
        .irq      (irq)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_desc
        localparam reg_sel_e ADDR_SEL = (b == 0) ? SEL_ADDR_A : SEL_ADDR_B;
        localparam reg_sel_e CNT_SEL  = (b == 0) ? SEL_CNT_A  : SEL_CNT_B;
        logic in_use;
        assign in_use = (ctl.biu == 1'(b));

        pp_dma_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
            .clk     (clk),
            .rst     (rst),
            .wr_addr (reg_we && sel == ADDR_SEL),
            .wr_cnt  (reg_we && sel == CNT_SEL),
            .wdata   (reg_wdata[ADDR_W-1:0]),
            .lock    (start_v[b] || (inflight && in_use)),
            .adv     (adv && in_use),
            .step    (step),
            .addr    (addr_q[b]),
            .cnt     (cnt_q[b])
        );
    end

    pp_dma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .alloc      (alloc),
        .cnt_act    (cnt_q[ctl.biu]),
        .step       (step),
        .periph_req (periph_req),
        .xfer_ready (xfer_ready),
        .inflight   (inflight),
        .adv        (adv),
        .complete   (complete)
    );

    assign xfer_valid = inflight;
    assign xfer_addr  = addr_q[ctl.biu];
    assign xfer_rx    = cfg.rx;
    assign xfer_wide  = cfg.wide;
    assign xfer_dev   = cfg.dev_sel;

    assign stat_word = REG_W'({ctl.biu, ctl.start_b, ctl.done_b, ctl.start_a,
                               ctl.done_a, ctl.ie, ctl.run | inflight});

    always_comb begin
        unique case (sel)
            SEL_CFG:    reg_rdata = cfg;
            SEL_ADDR_A: reg_rdata = REG_W'(addr_q[0]);
            SEL_CNT_A:  reg_rdata = REG_W'(cnt_q[0]);
            SEL_ADDR_B: reg_rdata = REG_W'(addr_q[1]);
            SEL_CNT_B:  reg_rdata = REG_W'(cnt_q[1]);
            default:    reg_rdata = stat_word;
        endcase
    end

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr)));

endmodule

// File: tb/pp_dma_channel_test.sv
module pp_dma_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_MASK   = 32'h1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b1;
    logic        xfer_ready = 1'b1;
    logic        xfer_valid;
    logic [31:0] xfer_addr;
    logic        xfer_rx, xfer_wide;
    logic [3:0]  xfer_dev;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pp_dma_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .xfer_ready(xfer_ready),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_rx(xfer_rx),
        .xfer_wide(xfer_wide), .xfer_dev(xfer_dev), .irq(irq)
    );

    // behavioural reference model
    bit          m_run, m_ie, m_biu, m_inf;
    bit          m_start [2];
    bit          m_done  [2];
    int unsigned m_addr  [2];
    int          m_cnt   [2];
    logic [31:0] m_cfg;
    int          a, stp;
    bit          ack, comp, issue;
    bit          lk [2];

    function automatic logic [31:0] m_status();
        return {25'b0, m_biu, m_start[1], m_done[1], m_start[0], m_done[0],
                m_ie, m_run | m_inf};
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_cfg;
            3'd4: return m_addr[0];
            3'd5: return m_cnt[0];
            3'd6: return m_addr[1];
            3'd7: return m_cnt[1];
            default: return m_status();
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_ie = 0; m_biu = 0; m_inf = 0; m_cfg = 0;
            for (int i = 0; i < 2; i++) begin
                m_start[i] = 0; m_done[i] = 0; m_addr[i] = 0; m_cnt[i] = 0;
            end
        end else begin
            a = m_biu;
            stp = m_cfg[3] ? 2 : 1;
            ack = m_inf && xfer_ready;
            comp = 0; issue = 0;
            for (int i = 0; i < 2; i++) lk[i] = m_start[i] || (m_inf && a == i);
            if (ack) begin
                m_addr[a] = m_addr[a] + stp;
                m_cnt[a] = (m_cnt[a] <= stp) ? 0 : m_cnt[a] - stp;
                comp = (m_cnt[a] == 0);
            end else if (!m_inf && m_run && m_cfg != 0 && m_start[a]) begin
                if (m_cnt[a] == 0) comp = 1;
                else if (periph_req) issue = 1;
            end
            if (reg_we) begin
                case (reg_sel)
                    3'd0: m_cfg = reg_wdata;
                    3'd1, 3'd2: begin
                        if (reg_wdata[0]) m_run      = (reg_sel == 3'd1);
                        if (reg_wdata[1]) m_ie       = (reg_sel == 3'd1);
                        if (reg_wdata[2]) m_done[0]  = (reg_sel == 3'd1);
                        if (reg_wdata[3]) m_start[0] = (reg_sel == 3'd1);
                        if (reg_wdata[4]) m_done[1]  = (reg_sel == 3'd1);
                        if (reg_wdata[5]) m_start[1] = (reg_sel == 3'd1);
                    end
                    3'd4: if (!lk[0]) m_addr[0] = reg_wdata;
                    3'd5: if (!lk[0]) m_cnt[0]  = reg_wdata & CNT_MASK;
                    3'd6: if (!lk[1]) m_addr[1] = reg_wdata;
                    3'd7: if (!lk[1]) m_cnt[1]  = reg_wdata & CNT_MASK;
                    default: ;
                endcase
            end
            if (comp) begin
                m_done[a] = 1; m_start[a] = 0; m_biu = !m_biu;
            end
            if (ack) m_inf = 0;
            else if (issue) m_inf = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk("R5 valid", {31'b0, xfer_valid}, {31'b0, m_inf});
            chk("R9 irq", {31'b0, irq}, {31'b0, m_ie && (m_done[0] || m_done[1])});
            chk("R2 readback", reg_rdata, m_read(reg_sel));
            if (m_inf) begin
                chk("R6 beat address", xfer_addr, m_addr[m_biu]);
                chk("R5 beat attributes", {26'b0, xfer_rx, xfer_wide, xfer_dev},
                    {26'b0, m_cfg[0], m_cfg[3], m_cfg[7:4]});
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 3'd3;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #2 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, 32'h0);
        rd(3'd0, v); chk("R1 device word", v, 32'h0);
        chk("R1 irq/valid", {30'b0, irq, xfer_valid}, 32'h0);

        // R2 set / clear / status aliases
        wr(3'd1, 32'h7F); rd(3'd3, v); chk("R2 set alias", v, 32'h3F);
        chk("R9 irq with done", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h15); rd(3'd2, v); chk("R2 clear alias", v, 32'h2A);
        wr(3'd3, 32'hFF); rd(3'd1, v); chk("R2 status alias write ignored", v, 32'h2A);
        wr(3'd2, 32'h7F); rd(3'd3, v); chk("R2 clear all", v, 32'h0);

        // R3 descriptor lock
        wr(3'd4, 32'h1000); wr(3'd5, 32'd4);
        wr(3'd1, 32'h08);
        wr(3'd4, 32'h2222); wr(3'd5, 32'd9);
        rd(3'd4, v); chk("R3 locked address", v, 32'h1000);
        rd(3'd5, v); chk("R3 locked count", v, 32'd4);

        // R4 unallocated channel stays quiet
        wr(3'd1, 32'h01); idle(6);
        chk("R4 no beat", {31'b0, xfer_valid}, 32'h0);
        rd(3'd5, v); chk("R4 count untouched", v, 32'd4);

        // R5 R6 R7 byte beats on A, then idle since B unarmed
        wr(3'd0, 32'h00ABCD51); idle(20);
        rd(3'd4, v); chk("R6 address A", v, 32'h1004);
        rd(3'd5, v); chk("R6 count A", v, 32'd0);
        rd(3'd3, v); chk("R7 switch to B and idle", v, 32'h45);

        // R7 ping-pong with 2-byte beats, odd count on B
        wr(3'd2, 32'h04);
        wr(3'd0, 32'h00ABCD59);
        wr(3'd6, 32'h2000); wr(3'd7, 32'd3);
        wr(3'd4, 32'h3000); wr(3'd5, 32'd2);
        wr(3'd1, 32'h28); idle(20);
        rd(3'd6, v); chk("R6 address B wide", v, 32'h2004);
        rd(3'd7, v); chk("R6 odd count floors at zero", v, 32'd0);
        rd(3'd4, v); chk("R7 continued on A", v, 32'h3002);
        rd(3'd3, v); chk("R7 both done", v, 32'h55);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h02); chk("R9 irq enabled", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h16); chk("R9 irq cleared", {31'b0, irq}, 32'h0);

        // R8 pause with a held beat
        wr(3'd0, 32'h00ABCD51);
        wr(3'd6, 32'h4000); wr(3'd7, 32'd8);
        xfer_ready = 1'b0;
        wr(3'd1, 32'h20); idle(3);
        chk("R5 beat held", {31'b0, xfer_valid}, 32'h1);
        wr(3'd2, 32'h01);
        rd(3'd3, v); chk("R8 run status held", {31'b0, v[0]}, 32'h1);
        xfer_ready = 1'b1; idle(3);
        rd(3'd3, v); chk("R8 run status dropped", {31'b0, v[0]}, 32'h0);
        rd(3'd7, v); chk("R8 one beat done", v, 32'd7);
        idle(5);
        chk("R8 paused", {31'b0, xfer_valid}, 32'h0);
        wr(3'd1, 32'h01); idle(25);
        rd(3'd6, v); chk("R8 resumed to end", v, 32'h4008);
        rd(3'd3, v); chk("R7 idle on A", v, 32'h11);

        // R7 zero-count start completes without a beat
        wr(3'd1, 32'h08); idle(3);
        rd(3'd3, v); chk("R7 zero count completion", v, 32'h55);
        rd(3'd4, v); chk("R7 address unchanged", v, 32'h3002);
        wr(3'd2, 32'h14);

        // R5 no beat without peripheral request
        periph_req = 1'b0;
        wr(3'd6, 32'h6000); wr(3'd7, 32'd2);
        wr(3'd1, 32'h20); idle(5);
        chk("R5 waits for request", {31'b0, xfer_valid}, 32'h0);
        periph_req = 1'b1; idle(10);
        rd(3'd7, v); chk("R5 drained after request", v, 32'd0);

        // stalling ready pattern on A with 2-byte beats
        wr(3'd0, 32'h00ABCD59);
        wr(3'd4, 32'h5000); wr(3'd5, 32'd20);
        wr(3'd1, 32'h08);
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            xfer_ready = (i % 3) != 0;
        end
        xfer_ready = 1'b1; idle(20);
        rd(3'd4, v); chk("R6 address after stalls", v, 32'h5014);
        rd(3'd5, v); chk("R6 count after stalls", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule